// File: doc/BRIEF.md
# Sector Group Protection Gate

This block sits between the command decoder of a 2M x 8 flash array and its program/erase engine and decides, per request, which sectors may actually be touched. The array is split into 32 uniform 64 KB sectors, and the sectors are collected four at a time into 8 protection groups. Each group has one stored protect bit. A program request names one byte address. A sector erase request names any set of sectors through a 32-bit mask. A chip erase names every sector. The gate returns a registered verdict one clock after the request strobe: a grant flag, a reject flag and the set of sectors that may proceed.

A temporary unprotect mode opens every group while a dedicated high-voltage-indication input is held high. The stored protect bits are not altered, so the earlier protection returns as soon as the input falls. The protect bits are written only through a mask load port, and that port is ignored while the mode is open. When autoselect mode is on, a combinational ID path returns a manufacturer code, a device code, or the stored protect status of the group selected by the address.

Control is a two-state machine. GUARD is the reset state, and in it the stored bits apply. OPEN is entered on the clock edge that samples the unlock input high (transition GUARD->OPEN). It is left on the edge that samples the input low (transition OPEN->GUARD). Every other edge keeps the current state.

Top module: `sgp_gate`

## Requirements
- R1: The sector index is address bits 20..16 and the group index is bits 20..18, so group n covers sectors 4n..4n+3. Protect-mask bit n guards group n.
- R2: A program request (kind 00) aimed at a guarded group gives grant=0, reject=1 and an empty sector set. Aimed at an open group, it gives grant=1, reject=0 and a set holding only bit addr[20:16].
- R3: A sector erase request (kind 01) checks each set bit i of the sector mask against group i/4. Guarded sectors are dropped from the set. reject=1 if any sector was dropped, and grant=1 if any sector remains.
- R4: A chip erase request (kind 10) grants every sector of every unguarded group. It reports reject=1 when at least one group is guarded.
- R5: From the clock after the unlock input is sampled high, every request is granted in full with reject=0. From the clock after it is sampled low, the stored protection applies again unchanged.
- R6: A load strobe replaces the protect bits with the 8-bit mask from the next clock. A load strobe is ignored while the unlock mode is open.
- R7: After reset, all groups are unguarded and grant, reject and the sector set are all zero.
- R8: The verdict is registered. It appears exactly one clock after the request strobe and is all zero in any cycle that follows a clock with no strobe.
- R9: With autoselect on and address bit 6 = 0, the ID byte depends on address bits 1..0. Value 00 gives 01h and value 01 gives 3Dh. Value 10 gives 01h if the stored bit of group addr[20:18] is set and 00h if it is clear, even while the unlock mode is open. Every other case, including autoselect off, gives 00h.
- R10: Request kind 11 grants nothing and rejects nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 chip erase, 11 none |
| req_addr | input | 21 | Byte address (program target, ID selection) |
| req_sectors | input | 32 | Sector set for a sector erase, bit i = sector i |
| hv_unlock | input | 1 | Temporary unprotect indication |
| prot_load | input | 1 | Protect mask load strobe |
| prot_mask | input | 8 | New protect bits, bit n = group n |
| asel_mode | input | 1 | Autoselect mode flag |
| grant | output | 1 | At least one sector may proceed |
| reject | output | 1 | At least one targeted sector was blocked |
| grant_sectors | output | 32 | Sectors allowed to proceed |
| id_byte | output | 8 | Autoselect ID or protect status |

## Verification
The hardest situation to reach is a protect-mask load arriving while the unlock mode is open. When it is ignored, the requests still pass because every group is open, so nothing at the verdict port shows whether the load was dropped. The bench therefore loads an all-ones mask during the mode and reads the stored status back through the autoselect ID path while the mode is still open. It then closes the mode and programs into a group that the ignored mask would have guarded. Sector boundary addresses on both sides of a group edge, and erase sets that are fully, partly and not at all blocked, cover the per-sector drop logic.

// File: rtl/sgp_pkg.sv
package sgp_pkg;
    localparam int unsigned ADDR_W    = 21;
    localparam int unsigned SECT_BITS = 5;
    localparam int unsigned GRP_BITS  = 3;
    localparam int unsigned N_SECT    = 1 << SECT_BITS;
    localparam int unsigned N_GRP     = 1 << GRP_BITS;
    localparam int unsigned SECT_PER_GRP = N_SECT / N_GRP;
    localparam int unsigned ID_W      = 8;
    localparam int unsigned ASEL_GATE_BIT = 6;
    localparam logic [ID_W-1:0] ID_MFR  = 8'h01;
    localparam logic [ID_W-1:0] ID_DEV  = 8'h3D;
    localparam logic [ID_W-1:0] ID_PROT = 8'h01;

    typedef enum logic [1:0] {
        K_PROG   = 2'b00,
        K_SERASE = 2'b01,
        K_CERASE = 2'b10,
        K_NONE   = 2'b11
    } req_kind_e;

    typedef enum logic [0:0] {
        ST_GUARD = 1'b0,
        ST_OPEN  = 1'b1
    } gate_state_e;

    // Expand one bit per group into one bit per sector.
    function automatic logic [N_SECT-1:0] grp_to_sect(input logic [N_GRP-1:0] g);
        logic [N_SECT-1:0] s;
        for (int i = 0; i < N_SECT; i++) begin
            s[i] = g[i / SECT_PER_GRP];
        end
        return s;
    endfunction
endpackage

// File: rtl/sgp_prot_store.sv
module sgp_prot_store
    import sgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [N_GRP-1:0] load_mask,
    output logic [N_GRP-1:0] prot_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_q <= '0;
        end else if (load_en) begin
            prot_q <= load_mask;
        end
    end
endmodule

// File: rtl/sgp_scope.sv
module sgp_scope
    import sgp_pkg::*;
(
    input  logic [1:0]        kind,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_SECT-1:0] sel,
    input  logic [N_GRP-1:0]  eff_prot,
    output logic [N_SECT-1:0] allowed,
    output logic              dropped
);
    logic [SECT_BITS-1:0] sect_idx;
    logic [N_SECT-1:0]    want;
    logic [N_SECT-1:0]    blocked;

    assign sect_idx = addr[ADDR_W-1 -: SECT_BITS];
    assign blocked  = grp_to_sect(eff_prot);

    always_comb begin
        want = '0;
        unique case (req_kind_e'(kind))
            K_PROG:   want[sect_idx] = 1'b1;
            K_SERASE: want = sel;
            K_CERASE: want = '1;
            K_NONE:   want = '0;
        endcase
    end

    assign allowed = want & ~blocked;
    assign dropped = |(want & blocked);
endmodule

// File: rtl/sgp_id_mux.sv
module sgp_id_mux
    import sgp_pkg::*;
(
    input  logic              asel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N_GRP-1:0]  prot,
    output logic [ID_W-1:0]   id
);
    logic [GRP_BITS-1:0] grp_idx;
    assign grp_idx = addr[ADDR_W-1 -: GRP_BITS];

    always_comb begin
        id = '0;
        if (asel && !addr[ASEL_GATE_BIT]) begin
            unique case (addr[1:0])
                2'b00:   id = ID_MFR;
                2'b01:   id = ID_DEV;
                2'b10:   id = prot[grp_idx] ? ID_PROT : '0;
                default: id = '0;
            endcase
        end
    end
endmodule

// File: rtl/sgp_gate.sv
module sgp_gate
    import sgp_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [N_SECT-1:0]   req_sectors,
    input  logic                hv_unlock,
    input  logic                prot_load,
    input  logic [N_GRP-1:0]    prot_mask,
    input  logic                asel_mode,
    output logic                grant,
    output logic                reject,
    output logic [N_SECT-1:0]   grant_sectors,
    output logic [ID_W-1:0]     id_byte
);
    gate_state_e       state_q, state_d;
    logic [N_GRP-1:0]  prot_q;
    logic [N_GRP-1:0]  eff_prot;
    logic [N_SECT-1:0] allowed;
    logic              dropped;
    logic              load_ok;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_GUARD;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_GUARD: if (hv_unlock)  state_d = ST_OPEN;
            ST_OPEN:  if (!hv_unlock) state_d = ST_GUARD;
        endcase
    end

    assign load_ok  = prot_load && (state_q == ST_GUARD);
    assign eff_prot = (state_q == ST_OPEN) ? '0 : prot_q;

    sgp_prot_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_ok),
        .load_mask (prot_mask),
        .prot_q    (prot_q)
    );

    sgp_scope u_scope (
        .kind     (req_kind),
        .addr     (req_addr),
        .sel      (req_sectors),
        .eff_prot (eff_prot),
        .allowed  (allowed),
        .dropped  (dropped)
    );

    sgp_id_mux u_id (
        .asel (asel_mode),
        .addr (req_addr),
        .prot (prot_q),
        .id   (id_byte)
    );

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant         <= 1'b0;
            reject        <= 1'b0;
            grant_sectors <= '0;
        end else if (req_valid) begin
            grant         <= |allowed;
            reject        <= dropped;
            grant_sectors <= allowed;
        end else begin
            grant         <= 1'b0;
            reject        <= 1'b0;
            grant_sectors <= '0;
        end
    end
endmodule

// File: rtl/sgp_gate_chk.sv
module sgp_gate_chk
    import sgp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [1:0]        req_kind,
    input logic              grant,
    input logic              reject,
    input logic [N_SECT-1:0] grant_sectors,
    input logic              open_q,
    input logic [N_GRP-1:0]  prot_q
);
    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(req_valid) |-> (!grant && !reject && grant_sectors == '0));

    // R2
    prog_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_kind == K_PROG) |-> (grant != reject));

    // R2
    prog_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(req_valid && req_kind == K_PROG) && grant) |-> ($countones(grant_sectors) == 1));

    // R3
    no_guarded_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !open_q) |-> ((grant_sectors & grp_to_sect($past(prot_q))) == '0));

    // R5
    open_no_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && open_q) |-> !reject);

    // R6
    frozen_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        open_q |=> $stable(prot_q));

    // R10
    none_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_kind == K_NONE) |-> (!grant && !reject));
endmodule

bind sgp_gate sgp_gate_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_kind      (req_kind),
    .grant         (grant),
    .reject        (reject),
    .grant_sectors (grant_sectors),
    .open_q        (state_q == sgp_pkg::ST_OPEN),
    .prot_q        (prot_q)
);

// File: tb/tb_sgp_gate.sv
`timescale 1ns/1ps
module tb_sgp_gate;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [20:0] req_addr = '0;
    logic [31:0] req_sectors = '0;
    logic        hv_unlock = 1'b0;
    logic        prot_load = 1'b0;
    logic [7:0]  prot_mask = '0;
    logic        asel_mode = 1'b0;
    logic        grant, reject;
    logic [31:0] grant_sectors;
    logic [7:0]  id_byte;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    sgp_gate dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_sectors(req_sectors), .hv_unlock(hv_unlock),
        .prot_load(prot_load), .prot_mask(prot_mask), .asel_mode(asel_mode),
        .grant(grant), .reject(reject), .grant_sectors(grant_sectors), .id_byte(id_byte)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request, check the verdict one clock later, then check it clears.
    task automatic do_req(input string tag, input logic [1:0] k, input logic [20:0] a,
                          input logic [31:0] sel, input logic eg, input logic er,
                          input logic [31:0] es);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_addr = a; req_sectors = sel;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " grant"},  {31'd0, grant},  {31'd0, eg});
        check({tag, " reject"}, {31'd0, reject}, {31'd0, er});
        check({tag, " set"},    grant_sectors,   es);
    endtask

    task automatic load(input logic [7:0] m);
        @(negedge clk);
        prot_load = 1'b1; prot_mask = m;
        @(negedge clk);
        prot_load = 1'b0;
    endtask

    task automatic id_read(input string tag, input logic [20:0] a, input logic [7:0] exp);
        @(negedge clk);
        asel_mode = 1'b1; req_addr = a;
        #1;
        check(tag, {24'd0, id_byte}, {24'd0, exp});
        asel_mode = 1'b0;
    endtask

    task automatic t_reset;
        check("R7 reset grant",  {31'd0, grant},  32'd0);
        check("R7 reset reject", {31'd0, reject}, 32'd0);
        check("R7 reset set",    grant_sectors,   32'd0);
        do_req("R7 chip erase after reset", 2'b10, '0, '0, 1'b1, 1'b0, 32'hFFFF_FFFF);
    endtask

    task automatic t_program;
        load(8'b0000_0101); // R6: groups 0 and 2 guarded
        do_req("R2 prog open group",   2'b00, 21'h05_1234, '0, 1'b1, 1'b0, 32'h0000_0020);
        do_req("R2 prog guarded",      2'b00, 21'h0A_0000, '0, 1'b0, 1'b1, 32'h0);
        do_req("R1 last byte group0",  2'b00, 21'h03_FFFF, '0, 1'b0, 1'b1, 32'h0);
        do_req("R1 first byte group1", 2'b00, 21'h04_0000, '0, 1'b1, 1'b0, 32'h0000_0010);
        @(negedge clk);
        check("R8 idle after request", {30'd0, grant, reject}, 32'd0);
    endtask

    task automatic t_erase;
        do_req("R3 partial drop",  2'b01, '0, 32'h0000_1111, 1'b1, 1'b1, 32'h0000_1010);
        do_req("R3 none dropped",  2'b01, '0, 32'hF000_0000, 1'b1, 1'b0, 32'hF000_0000);
        do_req("R3 all dropped",   2'b01, '0, 32'h0000_0F00, 1'b0, 1'b1, 32'h0);
        do_req("R4 chip erase",    2'b10, '0, '0, 1'b1, 1'b1, 32'hFFFF_F0F0);
        do_req("R10 kind none",    2'b11, 21'h05_0000, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic t_id;
        id_read("R9 manufacturer",    21'h00_0000, 8'h01);
        id_read("R9 device",          21'h00_0001, 8'h3D);
        id_read("R9 group2 guarded",  21'h08_0002, 8'h01);
        id_read("R9 group1 open",     21'h04_0002, 8'h00);
        id_read("R9 bit6 set",        21'h00_0040, 8'h00);
        id_read("R9 code 11",         21'h00_0003, 8'h00);
        @(negedge clk);
        req_addr = 21'h00_0001; #1;
        check("R9 autoselect off", {24'd0, id_byte}, 32'd0);
    endtask

    task automatic t_unlock;
        @(negedge clk); hv_unlock = 1'b1;
        do_req("R5 open prog guarded", 2'b00, 21'h0A_0000, '0, 1'b1, 1'b0, 32'h0000_0400);
        do_req("R5 open chip erase",   2'b10, '0, '0, 1'b1, 1'b0, 32'hFFFF_FFFF);
        load(8'hFF); // R6: must be ignored
        id_read("R6 load ignored group3", 21'h0C_0002, 8'h00);
        id_read("R9 status while open",   21'h00_0002, 8'h01);
        @(negedge clk); hv_unlock = 1'b0;
        do_req("R5 restored guard",    2'b00, 21'h0A_0000, '0, 1'b0, 1'b1, 32'h0);
        do_req("R6 group3 still open", 2'b00, 21'h0D_0000, '0, 1'b1, 1'b0, 32'h0000_2000);
    endtask

    task automatic t_reload;
        load(8'h80);
        do_req("R6 new mask top",    2'b00, 21'h1F_0000, '0, 1'b0, 1'b1, 32'h0);
        do_req("R6 old guard gone",  2'b00, 21'h0A_0000, '0, 1'b1, 1'b0, 32'h0000_0400);
        id_read("R9 group7 guarded", 21'h1C_0002, 8'h01);
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #1000000;
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_program();
        t_erase();
        t_id();
        t_unlock();
        t_reload();
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule